// File: doc/BRIEF.md
# Counter Access Permission Checker

This block sits beside the counter CSR file of a processor hart and decides, for every access to a counter address, whether the access may go ahead, must raise an illegal-instruction fault or must raise a virtual-instruction fault. It takes the current privilege level and the virtualization bit, and checks them against three enable masks. The machine mask gates every mode below M. The hypervisor mask adds a gate for the guest modes. The supervisor mask adds a gate for the two user modes. The counters themselves live elsewhere. This block only produces the verdict.

It also serves reads of the supervisor overflow-vector CSR. That CSR shows the per-counter overflow flags, filtered by the enable masks that apply to the reader's mode. The enable masks are captured into registers that clear on reset. Each verdict and each read-data word is registered, so it appears one clock after the request.

Top module: `ctr_access_guard`

## Requirements
- R1: All three outputs are registered. They reflect the request presented in the previous cycle, and they are 0 while `rst_n` is low.
- R2: The enable masks are held in registers that reset to 0. A mask value takes effect on requests made in the cycle after it is presented, so the first request after reset sees all-zero masks.
- R3: Mode encoding: `priv_i` = 3 is M, 1 is S and 0 is U (2 is treated as U). `virt_i` = 1 selects VS/VU and is ignored in M. A read from M of a user counter (0xC00–0xC1F) or of a machine counter (0xB00, 0xB02–0xB1F) never faults.
- R4: Below M, a read of user counter address A with machine mask bit A[4:0] clear raises an illegal-instruction fault.
- R5: In HU, a read with the machine bit set and the supervisor bit A[4:0] clear raises an illegal-instruction fault. With both bits set, the read is allowed.
- R6: In VS or VU, a read with the machine bit set and the hypervisor bit A[4:0] clear raises a virtual-instruction fault.
- R7: In VU, a read with the machine and hypervisor bits set and the supervisor bit clear raises a virtual-instruction fault. With all three bits set, the read is allowed.
- R8: A write strobe to any user counter address raises an illegal-instruction fault in every mode, including M, whatever the masks hold.
- R9: Any access to a machine counter address from a mode below M raises an illegal-instruction fault.
- R10: A read of the overflow vector (address 0xDA0) always returns 0 in bits 2:0. From M it returns flags 31:3 unfiltered.
- R11: An overflow-vector read from HS returns the flags ANDed with the machine mask. From VS it returns the flags ANDed with both the machine and hypervisor masks.
- R12: An overflow-vector read from HU raises an illegal-instruction fault and from VU a virtual-instruction fault. A write to 0xDA0 raises an illegal-instruction fault in any mode.
- R13: The two faults are never raised together. The read data is 0 unless an allowed overflow-vector read was made. Addresses outside the three ranges never fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr_i | input | 12 | CSR address of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| priv_i | input | 2 | Current privilege level (3 M, 1 S, 0 U) |
| virt_i | input | 1 | Virtualization mode active |
| mcen_i | input | 32 | Machine counter-enable mask |
| hcen_i | input | 32 | Hypervisor counter-enable mask |
| scen_i | input | 32 | Supervisor counter-enable mask |
| ovf_flags_i | input | 32 | Per-counter overflow flags |
| ill_o | output | 1 | Illegal-instruction fault |
| vill_o | output | 1 | Virtual-instruction fault |
| ovf_rdata_o | output | 32 | Overflow-vector read data |

## Verification
The bench checks the layered denial order. It pairs masks so that exactly one layer denies an access, which separates the illegal fault from the virtual fault. A design that tests the masks in the wrong order, or that uses one fault type for every denial, reports the wrong fault on these vectors.

It also covers:
- The extreme counter indices 0 and 31. A wrong index slice would gate these against the wrong bit.
- A write from M to a read-only counter, which a design that lets M bypass every check would wrongly accept.
- Overflow-vector reads in each mode, where a missing mask term leaks flags that should read as 0.
- The first request right after reset. A design that feeds the masks straight through, instead of starting from cleared mask registers, lets that request through.

// File: rtl/ctr_guard_pkg.sv
package ctr_guard_pkg;

    localparam int CSR_AW = 12;

    localparam logic [CSR_AW-1:0] UCTR_BASE = 12'hC00;
    localparam logic [CSR_AW-1:0] MCTR_BASE = 12'hB00;
    localparam logic [CSR_AW-1:0] OVF_ADDR  = 12'hDA0;

    localparam int FIRST_EVENT_IDX = 3;

    typedef enum logic [2:0] {
        MD_M,
        MD_HS,
        MD_HU,
        MD_VS,
        MD_VU
    } mode_e;

    typedef enum logic [1:0] {
        AC_NONE,
        AC_UCTR,
        AC_MCTR,
        AC_OVF
    } acc_cls_e;

    function automatic mode_e to_mode(input logic [1:0] priv, input logic virt);
        mode_e m;
        if (priv == 2'b11)      m = MD_M;
        else if (priv == 2'b01) m = virt ? MD_VS : MD_HS;
        else                    m = virt ? MD_VU : MD_HU;
        return m;
    endfunction

endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode
    import ctr_guard_pkg::*;
#(
    parameter int MASK_W = 32,
    localparam int IDX_W = $clog2(MASK_W)
) (
    input  logic [CSR_AW-1:0] addr_i,
    output acc_cls_e          cls_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int PAGE_LSB = IDX_W;

    logic u_hit;
    logic m_hit;

    always_comb begin
        u_hit = (addr_i[CSR_AW-1:PAGE_LSB] == UCTR_BASE[CSR_AW-1:PAGE_LSB]);
        // index 1 of the machine page is not a counter
        m_hit = (addr_i[CSR_AW-1:PAGE_LSB] == MCTR_BASE[CSR_AW-1:PAGE_LSB])
                && (addr_i[PAGE_LSB-1:0] != IDX_W'(1));
        idx_o = addr_i[IDX_W-1:0];
        if (u_hit)                 cls_o = AC_UCTR;
        else if (m_hit)            cls_o = AC_MCTR;
        else if (addr_i == OVF_ADDR) cls_o = AC_OVF;
        else                       cls_o = AC_NONE;
    end

endmodule

// File: rtl/ctr_perm_eval.sv
module ctr_perm_eval
    import ctr_guard_pkg::*;
#(
    parameter int MASK_W = 32,
    localparam int IDX_W = $clog2(MASK_W)
) (
    input  mode_e             mode_i,
    input  acc_cls_e          cls_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [MASK_W-1:0] mcen_i,
    input  logic [MASK_W-1:0] hcen_i,
    input  logic [MASK_W-1:0] scen_i,
    output logic              ill_o,
    output logic              vill_o
);
    logic m_ok;
    logic h_ok;
    logic s_ok;
    logic guest;

    always_comb begin
        m_ok   = mcen_i[idx_i];
        h_ok   = hcen_i[idx_i];
        s_ok   = scen_i[idx_i];
        guest  = (mode_i == MD_VS) || (mode_i == MD_VU);
        ill_o  = 1'b0;
        vill_o = 1'b0;
        unique case (cls_i)
            AC_UCTR: begin
                if (wr_i) begin
                    ill_o = 1'b1;
                end else if (rd_i && mode_i != MD_M) begin
                    if (!m_ok)                              ill_o  = 1'b1;
                    else if (guest && !h_ok)                vill_o = 1'b1;
                    else if (mode_i == MD_HU && !s_ok)      ill_o  = 1'b1;
                    else if (mode_i == MD_VU && !s_ok)      vill_o = 1'b1;
                end
            end
            AC_MCTR: begin
                if ((rd_i || wr_i) && mode_i != MD_M) ill_o = 1'b1;
            end
            AC_OVF: begin
                if (wr_i)                               ill_o  = 1'b1;
                else if (rd_i && mode_i == MD_HU)       ill_o  = 1'b1;
                else if (rd_i && mode_i == MD_VU)       vill_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctr_ovf_view.sv
module ctr_ovf_view
    import ctr_guard_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  mode_e             mode_i,
    input  logic [MASK_W-1:0] flags_i,
    input  logic [MASK_W-1:0] mcen_i,
    input  logic [MASK_W-1:0] hcen_i,
    output logic [MASK_W-1:0] view_o
);
    logic [MASK_W-1:0] sel;

    always_comb begin
        unique case (mode_i)
            MD_M:    sel = '1;
            MD_HS:   sel = mcen_i;
            MD_VS:   sel = mcen_i & hcen_i;
            default: sel = '0;
        endcase
    end

    for (genvar b = 0; b < MASK_W; b++) begin : g_bit
        if (b < FIRST_EVENT_IDX) begin : g_fixed
            assign view_o[b] = 1'b0;
        end else begin : g_event
            assign view_o[b] = flags_i[b] & sel[b];
        end
    end

endmodule

// File: rtl/ctr_access_guard.sv
module ctr_access_guard
    import ctr_guard_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       csr_addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic [MASK_W-1:0] mcen_i,
    input  logic [MASK_W-1:0] hcen_i,
    input  logic [MASK_W-1:0] scen_i,
    input  logic [MASK_W-1:0] ovf_flags_i,
    output logic              ill_o,
    output logic              vill_o,
    output logic [MASK_W-1:0] ovf_rdata_o
);
    localparam int IDX_W = $clog2(MASK_W);

    typedef struct packed {
        logic              ill;
        logic              vill;
        logic [MASK_W-1:0] rdata;
        logic [MASK_W-1:0] mcen;
        logic [MASK_W-1:0] hcen;
        logic [MASK_W-1:0] scen;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    mode_e            mode;
    acc_cls_e         cls;
    logic [IDX_W-1:0] idx;
    logic             ill_c;
    logic             vill_c;
    logic [MASK_W-1:0] view;

    assign mode = to_mode(priv_i, virt_i);

    ctr_addr_decode #(.MASK_W(MASK_W)) i_dec (
        .addr_i (csr_addr_i),
        .cls_o  (cls),
        .idx_o  (idx)
    );

    ctr_perm_eval #(.MASK_W(MASK_W)) i_perm (
        .mode_i (mode),
        .cls_i  (cls),
        .idx_i  (idx),
        .rd_i   (rd_i),
        .wr_i   (wr_i),
        .mcen_i (st_q.mcen),
        .hcen_i (st_q.hcen),
        .scen_i (st_q.scen),
        .ill_o  (ill_c),
        .vill_o (vill_c)
    );

    ctr_ovf_view #(.MASK_W(MASK_W)) i_view (
        .mode_i  (mode),
        .flags_i (ovf_flags_i),
        .mcen_i  (st_q.mcen),
        .hcen_i  (st_q.hcen),
        .view_o  (view)
    );

    always_comb begin
        st_d       = st_q;
        st_d.mcen  = mcen_i;
        st_d.hcen  = hcen_i;
        st_d.scen  = scen_i;
        st_d.ill   = ill_c;
        st_d.vill  = vill_c;
        st_d.rdata = (cls == AC_OVF && rd_i && !wr_i && !ill_c && !vill_c) ? view : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ill_o       = st_q.ill;
    assign vill_o      = st_q.vill;
    assign ovf_rdata_o = st_q.rdata;

endmodule

// File: rtl/ctr_access_guard_chk.sv
module ctr_access_guard_chk #(
    parameter int MASK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [11:0]       csr_addr_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [1:0]        priv_i,
    input logic              ill_o,
    input logic              vill_o,
    input logic [MASK_W-1:0] ovf_rdata_o
);
    // R13
    one_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ill_o && vill_o));

    // R10
    ovf_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_rdata_o[2:0] == 3'b000);

    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && csr_addr_i[11:5] == 7'h60) |=> ill_o);

    // R3
    mmode_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i && priv_i == 2'b11 && csr_addr_i[11:5] == 7'h60) |=> (!ill_o && !vill_o));

    // R9
    mctr_low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && priv_i != 2'b11 && csr_addr_i == 12'hB00) |=> ill_o);

    // R13
    data_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_rdata_o != '0) |-> $past(rd_i && csr_addr_i == 12'hDA0));

endmodule

bind ctr_access_guard ctr_access_guard_chk #(.MASK_W(MASK_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_addr_i  (csr_addr_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .priv_i      (priv_i),
    .ill_o       (ill_o),
    .vill_o      (vill_o),
    .ovf_rdata_o (ovf_rdata_o)
);

// File: tb/test_ctr_access_guard.sv
module test_ctr_access_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    typedef struct packed {
        logic [1:0]  priv;
        logic        virt;
        logic        rd;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] m;
        logic [31:0] h;
        logic [31:0] s;
        logic [31:0] flags;
        logic        eill;
        logic        evill;
        logic [31:0] edata;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R3 M read cycle, masks clear
        '{2'd3,1'b0,1'b1,1'b0,12'hC00,32'h0,32'h0,32'h0,32'h0,1'b0,1'b0,32'h0,4'd3},
        // R4 HS read cycle, machine bit clear
        '{2'd1,1'b0,1'b1,1'b0,12'hC00,32'h0,32'hFFFF_FFFF,32'hFFFF_FFFF,32'h0,1'b1,1'b0,32'h0,4'd4},
        // R4 HS read counter 3 allowed
        '{2'd1,1'b0,1'b1,1'b0,12'hC03,32'h8,32'h0,32'h0,32'h0,1'b0,1'b0,32'h0,4'd4},
        // R5 HU read instret, supervisor bit clear
        '{2'd0,1'b0,1'b1,1'b0,12'hC02,32'h4,32'h0,32'h0,32'h0,1'b1,1'b0,32'h0,4'd5},
        // R5 HU read instret allowed
        '{2'd0,1'b0,1'b1,1'b0,12'hC02,32'h4,32'h0,32'h4,32'h0,1'b0,1'b0,32'h0,4'd5},
        // R6 VS read counter 31, hyp bit clear
        '{2'd1,1'b1,1'b1,1'b0,12'hC1F,32'h8000_0000,32'h0,32'h0,32'h0,1'b0,1'b1,32'h0,4'd6},
        // R4 VS read counter 31, machine bit clear
        '{2'd1,1'b1,1'b1,1'b0,12'hC1F,32'h0,32'h8000_0000,32'h0,32'h0,1'b1,1'b0,32'h0,4'd4},
        // R6 VS read counter 31 allowed
        '{2'd1,1'b1,1'b1,1'b0,12'hC1F,32'h8000_0000,32'h8000_0000,32'h0,32'h0,1'b0,1'b0,32'h0,4'd6},
        // R7 VU read time, supervisor bit clear
        '{2'd0,1'b1,1'b1,1'b0,12'hC01,32'h2,32'h2,32'h0,32'h0,1'b0,1'b1,32'h0,4'd7},
        // R7 VU read time allowed
        '{2'd0,1'b1,1'b1,1'b0,12'hC01,32'h2,32'h2,32'h2,32'h0,1'b0,1'b0,32'h0,4'd7},
        // R8 M write to counter 5
        '{2'd3,1'b0,1'b0,1'b1,12'hC05,32'hFFFF_FFFF,32'hFFFF_FFFF,32'hFFFF_FFFF,32'h0,1'b1,1'b0,32'h0,4'd8},
        // R9 HS read machine cycle
        '{2'd1,1'b0,1'b1,1'b0,12'hB00,32'hFFFF_FFFF,32'h0,32'h0,32'h0,1'b1,1'b0,32'h0,4'd9},
        // R3 M read machine counter 2
        '{2'd3,1'b0,1'b1,1'b0,12'hB02,32'h0,32'h0,32'h0,32'h0,1'b0,1'b0,32'h0,4'd3},
        // R10 M overflow read, all flags
        '{2'd3,1'b0,1'b1,1'b0,12'hDA0,32'h0,32'h0,32'h0,32'hFFFF_FFFF,1'b0,1'b0,32'hFFFF_FFF8,4'd10},
        // R11 HS overflow read filtered by machine mask
        '{2'd1,1'b0,1'b1,1'b0,12'hDA0,32'h0000_00F0,32'h0,32'h0,32'hFFFF_FFFF,1'b0,1'b0,32'h0000_00F0,4'd11},
        // R11 VS overflow read filtered by both masks
        '{2'd1,1'b1,1'b1,1'b0,12'hDA0,32'hFF00_00F0,32'h0F00_0030,32'h0,32'hAAAA_AAAF,1'b0,1'b0,32'h0A00_0020,4'd11},
        // R12 HU overflow read
        '{2'd0,1'b0,1'b1,1'b0,12'hDA0,32'hFFFF_FFFF,32'hFFFF_FFFF,32'hFFFF_FFFF,32'hFFFF_FFFF,1'b1,1'b0,32'h0,4'd12},
        // R12 VU overflow read
        '{2'd0,1'b1,1'b1,1'b0,12'hDA0,32'hFFFF_FFFF,32'hFFFF_FFFF,32'hFFFF_FFFF,32'hFFFF_FFFF,1'b0,1'b1,32'h0,4'd12},
        // R12 M write to overflow vector
        '{2'd3,1'b0,1'b0,1'b1,12'hDA0,32'h0,32'h0,32'h0,32'hFFFF_FFFF,1'b1,1'b0,32'h0,4'd12},
        // R13 HU read of unrelated address
        '{2'd0,1'b0,1'b1,1'b0,12'h300,32'h0,32'h0,32'h0,32'hFFFF_FFFF,1'b0,1'b0,32'h0,4'd13}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [1:0]  priv_i = '0;
    logic        virt_i = 1'b0;
    logic [31:0] mcen_i = '0;
    logic [31:0] hcen_i = '0;
    logic [31:0] scen_i = '0;
    logic [31:0] ovf_flags_i = '0;
    logic        ill_o;
    logic        vill_o;
    logic [31:0] ovf_rdata_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctr_access_guard i_ctr_access_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_addr_i  (csr_addr_i),
        .rd_i        (rd_i),
        .wr_i        (wr_i),
        .priv_i      (priv_i),
        .virt_i      (virt_i),
        .mcen_i      (mcen_i),
        .hcen_i      (hcen_i),
        .scen_i      (scen_i),
        .ovf_flags_i (ovf_flags_i),
        .ill_o       (ill_o),
        .vill_o      (vill_o),
        .ovf_rdata_o (ovf_rdata_o)
    );

    task automatic check(input string tag, input logic eill, input logic evill, input logic [31:0] edata);
        total++;
        if (ill_o !== eill || vill_o !== evill || ovf_rdata_o !== edata) begin
            bad++;
            $display("FAIL %s: got ill=%0b vill=%0b data=%h, want ill=%0b vill=%0b data=%h",
                     tag, ill_o, vill_o, ovf_rdata_o, eill, evill, edata);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at 0 during reset despite a faulting request
        priv_i = 2'd0; rd_i = 1'b1; wr_i = 1'b1; csr_addr_i = 12'hC00;
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 1'b0, 32'h0);

        // R2: first request after reset sees cleared mask registers
        rst_n = 1'b1;
        wr_i = 1'b0; rd_i = 1'b1; priv_i = 2'd1; virt_i = 1'b0;
        mcen_i = '1; hcen_i = '1; scen_i = '1;
        @(negedge clk);
        check("R2 masks reset", 1'b1, 1'b0, 32'h0);
        // R2: same request one cycle later sees loaded masks
        @(negedge clk);
        check("R2 mask load", 1'b0, 1'b0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            rd_i = 1'b0; wr_i = 1'b0;
            mcen_i = VECS[i].m; hcen_i = VECS[i].h; scen_i = VECS[i].s;
            ovf_flags_i = VECS[i].flags;
            @(negedge clk);
            priv_i = VECS[i].priv; virt_i = VECS[i].virt;
            csr_addr_i = VECS[i].addr;
            rd_i = VECS[i].rd; wr_i = VECS[i].wr;
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].eill, VECS[i].evill, VECS[i].edata);
        end

        // R1: output follows request by one cycle, then returns to idle
        rd_i = 1'b0; wr_i = 1'b0;
        @(negedge clk);
        check("R1 idle after request", 1'b0, 1'b0, 32'h0);

        // R13: idle strobes on overflow address return no data
        priv_i = 2'd3; csr_addr_i = 12'hDA0; ovf_flags_i = '1;
        @(negedge clk);
        check("R13 no strobe", 1'b0, 1'b0, 32'h0);

        // R9: machine index 1 is not a counter, so no fault from HS
        priv_i = 2'd1; csr_addr_i = 12'hB01; rd_i = 1'b1;
        @(negedge clk);
        check("R9 hole", 1'b0, 1'b0, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule